// File: doc/BRIEF.md
# ONFI Timing-Mode Enable Sequencer

This block moves an attached ONFI NAND device into the fastest asynchronous timing mode it supports, then enables the controller's extended-data-out sampling. After a start pulse it checks two gating flags and the device's mode bitmask. If those allow it, the block selects chip 0 and programs the timing-mode feature with a set-feature command. It then reads the feature back with a get-feature command to confirm the value. The commands go out over a request/done/error handshake to a lower-level command engine that is not part of this block.

If the readback matches, the block releases the chip, latches the chosen mode, picks the matching controller clock rate and raises the EDO flag. If any step fails, it releases the chip, reports failure and leaves EDO off, so the controller stays on its normal timing. When the gating flags or the mask rule the device out, the block reports a skip without touching the device.

Top module: `onfi_mode_seq`

## Requirements
- R1: When start_i is accepted with onfi_cap_i low or plat_ok_i low, the block issues no command and asserts no chip select. One cycle later, status_o reads SKIP (2'd2).
- R2: The chosen mode is 5 when mode_mask_i bit 5 is set, and 4 when bit 5 is clear and bit 4 is set. With both bits clear the start ends in SKIP (2'd2) with no command and no chip select.
- R3: cs_req_o rises at least one cycle before the first command request and stays high while any command request is raised.
- R4: The first command is a set-feature (cmd_is_get_o = 0) at feature address 8'h01. Its 32-bit parameter carries the mode in bits [7:0] and zero in bits [31:8]. An error returned for it ends in FAIL.
- R5: The second command is a get-feature (cmd_is_get_o = 1) at address 8'h01. It ends in FAIL if the command errors or if cmd_rdata_i differs from the chosen mode.
- R6: cs_req_o is low for at least one cycle before status_o changes to OK or FAIL.
- R7: On success status_o = OK (2'd1), edo_en_o = 1 and mode_o = the chosen mode. clk_fast_o = 1 (100 MHz) for mode 5 and 0 (80 MHz) for mode 4.
- R8: On failure status_o = FAIL (2'd3), edo_en_o = 0, mode_o = 0 and clk_fast_o = 0.
- R9: A command request stays raised until cmd_done_i. If no done arrives, the request is withdrawn after exactly WDOG_CYCLES (default 4096) cycles and the run ends in FAIL.
- R10: A start pulse while busy_o is high is ignored. status_o, mode_o, clk_fast_o and edo_en_o keep their values until the next accepted start, which clears them.
- R11: After reset all outputs are low and status_o reads NONE (2'd0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse |
| onfi_cap_i | input | 1 | Device reports ONFI capability |
| plat_ok_i | input | 1 | Platform allows EDO operation |
| mode_mask_i | input | MASK_W | Supported async modes, bit n = mode n |
| cs_req_o | output | 1 | Chip 0 select request |
| cmd_req_o | output | 1 | Command request to engine |
| cmd_is_get_o | output | 1 | 0 = set-feature, 1 = get-feature |
| cmd_addr_o | output | 8 | Feature address |
| cmd_param_o | output | 32 | Parameter bytes, byte 0 in [7:0] |
| cmd_done_i | input | 1 | Command finished (one-cycle pulse) |
| cmd_err_i | input | 1 | Command error, valid with done |
| cmd_rdata_i | input | 8 | Byte 0 returned by get-feature |
| busy_o | output | 1 | Sequence in progress |
| mode_o | output | 3 | Latched mode after success |
| clk_fast_o | output | 1 | 1 = 100 MHz clock, 0 = 80 MHz |
| edo_en_o | output | 1 | EDO sampling enabled |
| status_o | output | 2 | 0 none, 1 ok, 2 skip, 3 fail |

## Verification
The assertions assume that the command engine raises cmd_done_i only while a request is pending, and only as a single-cycle pulse. They also assume that cmd_err_i and cmd_rdata_i are meaningful only in that cycle. The bench's engine model follows these rules: it waits for a request and counts a delay. It then pulses done once with the chosen error and data values, or never answers when told to hang. Start is driven as a single-cycle pulse between edges.

// File: rtl/onfi_seq_pkg.sv
package onfi_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_SEL      = 3'd1,
    ST_SET      = 3'd2,
    ST_GET      = 3'd3,
    ST_REL_OK   = 3'd4,
    ST_REL_FAIL = 3'd5
  } seq_state_t;

  localparam logic [1:0] STAT_NONE = 2'd0;
  localparam logic [1:0] STAT_OK   = 2'd1;
  localparam logic [1:0] STAT_SKIP = 2'd2;
  localparam logic [1:0] STAT_FAIL = 2'd3;

  localparam logic [7:0] FEAT_TIMING = 8'h01;
  localparam logic [2:0] MODE_TOP    = 3'd5;
  localparam logic [2:0] MODE_NEXT   = 3'd4;
endpackage

// File: rtl/onfi_mode_pick.sv
module onfi_mode_pick #(
  parameter int MASK_W = 8
) (
  input  logic [MASK_W-1:0] mask_i,
  output logic              ok_o,
  output logic [2:0]        mode_o
);
  import onfi_seq_pkg::*;

  always_comb begin
    ok_o   = 1'b0;
    mode_o = 3'd0;
    if (mask_i[MODE_TOP]) begin
      ok_o   = 1'b1;
      mode_o = MODE_TOP;
    end else if (mask_i[MODE_NEXT]) begin
      ok_o   = 1'b1;
      mode_o = MODE_NEXT;
    end
  end

  // R2: a valid pick is mode 5 or 4, and 5 wins whenever offered
  always_comb begin
    if (ok_o) assert_pick_legal_R2: assert (mode_o == MODE_TOP || mode_o == MODE_NEXT);
    if (mask_i[MODE_TOP]) assert_pick_top_R2: assert (ok_o && mode_o == MODE_TOP);
  end
endmodule

// File: rtl/onfi_cmd_wdog.sv
module onfi_cmd_wdog #(
  parameter int LIMIT = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wait_i,
  output logic expire_o
);
  localparam int CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(LIMIT - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign expire_o = wait_i && (cnt_q == LAST);

  always_comb begin
    cnt_en = 1'b1;
    if (!wait_i || expire_o) cnt_d = '0;
    else                     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R9: once expired, the sequencer must drop its wait and the counter restarts
  assert_wdog_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> (cnt_q == '0) && !expire_o);
endmodule

// File: rtl/onfi_mode_seq.sv
module onfi_mode_seq #(
  parameter int MASK_W      = 8,
  parameter int WDOG_CYCLES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              onfi_cap_i,
  input  logic              plat_ok_i,
  input  logic [MASK_W-1:0] mode_mask_i,
  output logic              cs_req_o,
  output logic              cmd_req_o,
  output logic              cmd_is_get_o,
  output logic [7:0]        cmd_addr_o,
  output logic [31:0]       cmd_param_o,
  input  logic              cmd_done_i,
  input  logic              cmd_err_i,
  input  logic [7:0]        cmd_rdata_i,
  output logic              busy_o,
  output logic [2:0]        mode_o,
  output logic              clk_fast_o,
  output logic              edo_en_o,
  output logic [1:0]        status_o
);
  import onfi_seq_pkg::*;

  seq_state_t state_q, state_d;
  logic [2:0] cur_mode_q, cur_mode_d;
  logic       cur_en;
  logic [2:0] mode_q, mode_d;
  logic       fast_q, fast_d;
  logic       edo_q, edo_d;
  logic [1:0] stat_q, stat_d;
  logic       out_en;

  logic       pick_ok;
  logic [2:0] pick_mode;
  logic       accept, go, timeout, cmd_bad, get_match;

  onfi_mode_pick #(.MASK_W(MASK_W)) u_pick (
    .mask_i (mode_mask_i),
    .ok_o   (pick_ok),
    .mode_o (pick_mode)
  );

  onfi_cmd_wdog #(.LIMIT(WDOG_CYCLES)) u_wdog (
    .clk      (clk),
    .rst_n    (rst_n),
    .wait_i   (cmd_req_o && !cmd_done_i),
    .expire_o (timeout)
  );

  assign accept    = start_i && (state_q == ST_IDLE);
  assign go        = accept && onfi_cap_i && plat_ok_i && pick_ok;
  assign cmd_bad   = (cmd_done_i && cmd_err_i) || timeout;
  assign get_match = cmd_done_i && !cmd_err_i && (cmd_rdata_i == {5'd0, cur_mode_q});

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:     if (go) state_d = ST_SEL;
      ST_SEL:      state_d = ST_SET;
      ST_SET: begin
        if (cmd_bad)         state_d = ST_REL_FAIL;
        else if (cmd_done_i) state_d = ST_GET;
      end
      ST_GET: begin
        if (get_match)                 state_d = ST_REL_OK;
        else if (cmd_done_i || timeout) state_d = ST_REL_FAIL;
      end
      ST_REL_OK:   state_d = ST_IDLE;
      ST_REL_FAIL: state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    cur_en     = go;
    cur_mode_d = pick_mode;
    out_en     = 1'b0;
    mode_d     = mode_q;
    fast_d     = fast_q;
    edo_d      = edo_q;
    stat_d     = stat_q;
    if (accept) begin
      out_en = 1'b1;
      mode_d = 3'd0;
      fast_d = 1'b0;
      edo_d  = 1'b0;
      stat_d = go ? STAT_NONE : STAT_SKIP;
    end else if (state_q == ST_REL_OK) begin
      out_en = 1'b1;
      mode_d = cur_mode_q;
      fast_d = (cur_mode_q == MODE_TOP);
      edo_d  = 1'b1;
      stat_d = STAT_OK;
    end else if (state_q == ST_REL_FAIL) begin
      out_en = 1'b1;
      mode_d = 3'd0;
      fast_d = 1'b0;
      edo_d  = 1'b0;
      stat_d = STAT_FAIL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cur_mode_q <= 3'd0;
      mode_q     <= 3'd0;
      fast_q     <= 1'b0;
      edo_q      <= 1'b0;
      stat_q     <= STAT_NONE;
    end else begin
      state_q <= state_d;
      if (cur_en) cur_mode_q <= cur_mode_d;
      if (out_en) begin
        mode_q <= mode_d;
        fast_q <= fast_d;
        edo_q  <= edo_d;
        stat_q <= stat_d;
      end
    end
  end

  assign cs_req_o     = (state_q == ST_SEL) || (state_q == ST_SET) || (state_q == ST_GET);
  assign cmd_req_o    = (state_q == ST_SET) || (state_q == ST_GET);
  assign cmd_is_get_o = (state_q == ST_GET);
  assign cmd_addr_o   = FEAT_TIMING;
  assign cmd_param_o  = {24'd0, 5'd0, cur_mode_q};
  assign busy_o       = (state_q != ST_IDLE);
  assign mode_o       = mode_q;
  assign clk_fast_o   = fast_q;
  assign edo_en_o     = edo_q;
  assign status_o     = stat_q;

  // R3: no command without chip select
  assert_cs_cover_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_req_o |-> cs_req_o);
  // R3: a command never starts in the same cycle the chip is selected
  assert_cs_lead_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_req_o) |-> $past(cs_req_o));
  // R6: chip released before a final status appears
  assert_release_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_o == STAT_OK || status_o == STAT_FAIL) && $past(status_o) == STAT_NONE)
      |-> !$past(cs_req_o));
  // R7: EDO only with success, a legal mode and the matching clock
  assert_edo_ok_R7: assert property (@(posedge clk) disable iff (!rst_n)
    edo_en_o |-> (status_o == STAT_OK) && (mode_o == MODE_TOP || mode_o == MODE_NEXT)
                 && (clk_fast_o == (mode_o == MODE_TOP)));
  // R8: failure leaves EDO off
  assert_fail_plain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o == STAT_FAIL) |-> !edo_en_o && !clk_fast_o);
  // R9: a pending request is held with stable contents until done or timeout
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req_o && !cmd_done_i && !timeout) |=>
      cmd_req_o && $stable(cmd_is_get_o) && $stable(cmd_param_o));
  // R10: status frozen while busy after the start cycle
  assert_status_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o) && state_q != ST_REL_OK && state_q != ST_REL_FAIL)
      |=> $stable(status_o) || !$past(busy_o, 1) );
endmodule

// File: tb/onfi_mode_seq_tb.sv
module onfi_mode_seq_tb_top;
  localparam int WDOG = 4096;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        onfi_cap_i = 1'b0;
  logic        plat_ok_i = 1'b0;
  logic [7:0]  mode_mask_i = 8'h00;
  logic        cs_req_o, cmd_req_o, cmd_is_get_o;
  logic [7:0]  cmd_addr_o;
  logic [31:0] cmd_param_o;
  logic        cmd_done_i = 1'b0;
  logic        cmd_err_i = 1'b0;
  logic [7:0]  cmd_rdata_i = 8'h00;
  logic        busy_o, clk_fast_o, edo_en_o;
  logic [2:0]  mode_o;
  logic [1:0]  status_o;

  int checks = 0;
  int errors = 0;

  // engine model controls and records
  int          eng_dly = 2;
  bit          eng_hang = 0;
  bit          eng_set_err = 0;
  bit          eng_get_err = 0;
  bit          eng_get_bad = 0;
  int          ncmd = 0;
  int          hang_cycles = 0;
  bit          cs_bad = 0;
  bit          order_bad = 0;
  logic [7:0]  set_addr, get_addr;
  logic [31:0] set_param;

  always #4 clk = ~clk;

  onfi_mode_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .onfi_cap_i(onfi_cap_i),
    .plat_ok_i(plat_ok_i), .mode_mask_i(mode_mask_i), .cs_req_o(cs_req_o),
    .cmd_req_o(cmd_req_o), .cmd_is_get_o(cmd_is_get_o), .cmd_addr_o(cmd_addr_o),
    .cmd_param_o(cmd_param_o), .cmd_done_i(cmd_done_i), .cmd_err_i(cmd_err_i),
    .cmd_rdata_i(cmd_rdata_i), .busy_o(busy_o), .mode_o(mode_o),
    .clk_fast_o(clk_fast_o), .edo_en_o(edo_en_o), .status_o(status_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // command engine responder
  initial begin
    forever begin
      @(negedge clk);
      if (cmd_req_o) begin
        ncmd++;
        if (!cs_req_o) cs_bad = 1;
        if (cmd_is_get_o != (ncmd % 2 == 0)) order_bad = 1;
        if (!cmd_is_get_o) begin
          set_addr  = cmd_addr_o;
          set_param = cmd_param_o;
        end else begin
          get_addr = cmd_addr_o;
        end
        if (eng_hang) begin
          hang_cycles = 1;
          while (cmd_req_o) begin
            @(negedge clk);
            if (cmd_req_o) hang_cycles++;
          end
        end else begin
          repeat (eng_dly) @(negedge clk);
          cmd_err_i   = cmd_is_get_o ? eng_get_err : eng_set_err;
          cmd_rdata_i = eng_get_bad ? (set_param[7:0] ^ 8'h01) : set_param[7:0];
          cmd_done_i  = 1'b1;
          @(negedge clk);
          cmd_done_i  = 1'b0;
          cmd_err_i   = 1'b0;
        end
      end
    end
  end

  task automatic run(input bit onfi, input bit plat, input logic [7:0] mask);
    onfi_cap_i  = onfi;
    plat_ok_i   = plat;
    mode_mask_i = mask;
    ncmd = 0; cs_bad = 0; order_bad = 0;
    @(negedge clk);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    while (busy_o) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic expect_out(input string req, input logic [1:0] st, input bit edo,
                            input logic [2:0] md, input bit fast);
    chk(status_o == st, {req, " status"}, status_o, st);
    chk(edo_en_o == edo, {req, " edo"}, edo_en_o, edo);
    chk(mode_o == md, {req, " mode"}, mode_o, md);
    chk(clk_fast_o == fast, {req, " clk"}, clk_fast_o, fast);
  endtask

  task automatic t_reset;
    // R11
    chk(status_o == 2'd0 && !busy_o && !cs_req_o && !cmd_req_o, "R11 reset idle", status_o, 0);
    chk(!edo_en_o && mode_o == 3'd0 && !clk_fast_o, "R11 reset outputs", mode_o, 0);
  endtask

  task automatic t_skip;
    run(1'b0, 1'b1, 8'h30);
    chk(ncmd == 0, "R1 no cmd when not onfi", ncmd, 0);
    expect_out("R1 not onfi", 2'd2, 1'b0, 3'd0, 1'b0);
    run(1'b1, 1'b0, 8'h30);
    chk(ncmd == 0 && !cs_req_o, "R1 no cmd when platform off", ncmd, 0);
    chk(status_o == 2'd2, "R1 platform skip", status_o, 2);
    run(1'b1, 1'b1, 8'h0F);
    chk(ncmd == 0 && !cs_req_o, "R2 no mode 4/5 untouched", ncmd, 0);
    chk(status_o == 2'd2, "R2 no mode skip", status_o, 2);
  endtask

  task automatic t_mode5;
    eng_dly = 3;
    run(1'b1, 1'b1, 8'h30);
    chk(ncmd == 2 && !order_bad, "R4 R5 set then get", ncmd, 2);
    chk(!cs_bad, "R3 cs during commands", cs_bad, 0);
    chk(set_addr == 8'h01, "R4 set address", set_addr, 1);
    chk(set_param == 32'h0000_0005, "R4 set param mode5", set_param, 5);
    chk(get_addr == 8'h01, "R5 get address", get_addr, 1);
    chk(!cs_req_o, "R6 released after ok", cs_req_o, 0);
    expect_out("R7 mode5", 2'd1, 1'b1, 3'd5, 1'b1);
    repeat (20) @(negedge clk);
    expect_out("R10 status held", 2'd1, 1'b1, 3'd5, 1'b1);
  endtask

  task automatic t_mode4;
    eng_dly = 0;
    run(1'b1, 1'b1, 8'h1F);
    chk(set_param == 32'h0000_0004, "R2 R4 param mode4", set_param, 4);
    expect_out("R7 mode4", 2'd1, 1'b1, 3'd4, 1'b0);
  endtask

  task automatic t_fail;
    eng_dly = 1;
    eng_set_err = 1;
    run(1'b1, 1'b1, 8'h30);
    eng_set_err = 0;
    chk(ncmd == 1, "R4 set error stops", ncmd, 1);
    chk(!cs_req_o, "R6 released after fail", cs_req_o, 0);
    expect_out("R8 set error", 2'd3, 1'b0, 3'd0, 1'b0);
    eng_get_err = 1;
    run(1'b1, 1'b1, 8'h30);
    eng_get_err = 0;
    expect_out("R5 get error", 2'd3, 1'b0, 3'd0, 1'b0);
    run(1'b1, 1'b1, 8'h30);   // success first so that failure must clear EDO
    eng_get_bad = 1;
    run(1'b1, 1'b1, 8'h10);
    eng_get_bad = 0;
    chk(ncmd == 2, "R5 mismatch both cmds", ncmd, 2);
    expect_out("R5 R8 readback mismatch", 2'd3, 1'b0, 3'd0, 1'b0);
  endtask

  task automatic t_timeout;
    eng_hang = 1;
    run(1'b1, 1'b1, 8'h30);
    eng_hang = 0;
    chk(hang_cycles == WDOG, "R9 watchdog length", hang_cycles, WDOG);
    chk(ncmd == 1, "R9 no get after timeout", ncmd, 1);
    expect_out("R9 timeout fail", 2'd3, 1'b0, 3'd0, 1'b0);
  endtask

  task automatic t_busy_start;
    eng_dly = 10;
    onfi_cap_i = 1'b1; plat_ok_i = 1'b1; mode_mask_i = 8'h30;
    ncmd = 0;
    @(negedge clk); start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    repeat (4) @(negedge clk);
    onfi_cap_i = 1'b0;              // would give SKIP if accepted
    start_i = 1'b1;
    @(negedge clk); start_i = 1'b0;
    chk(status_o == 2'd0, "R10 busy start ignored", status_o, 0);
    while (busy_o) @(negedge clk);
    @(negedge clk);
    chk(ncmd == 2, "R10 run continued", ncmd, 2);
    expect_out("R10 busy run result", 2'd1, 1'b1, 3'd5, 1'b1);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog run hung actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_skip();
    t_mode5();
    t_mode4();
    t_fail();
    t_timeout();
    t_busy_start();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule